// File: doc/BRIEF.md
# DRAM Compressed Test Mode Controller

This block is the test-mode logic of a four-pin DRAM whose storage is split, for every data pin, into four equal sub-blocks. It watches the active-low row strobe, column strobe and write enable on a system clock. It sorts each RAS cycle into a normal read, a normal write or one of four refresh kinds: CAS-before-RAS, write-CAS-before-RAS, RAS-only and hidden. It keeps a test-mode flag that these cycles set and clear.

In normal mode the two lowest column address bits choose one of the four sub-blocks for every pin, so each pin holds an ordinary bit. In test mode a write copies each pin's value into the same location of all four of that pin's sub-blocks. A read then reports, per pin, whether the four stored bits agree. A tester can therefore cover four cells per pin in one access. The cell array is a small register array.

Top module: `dram_testmode_ctrl`

## Requirements
- R1: A cycle whose CAS is low on the clock where RAS is first seen low is a refresh. A cycle where CAS falls while RAS is already low is an access: a write when WE is low at that CAS fall, otherwise a read.
- R2: Test mode is entered only by a refresh cycle with WE and CAS low before RAS falls, and only if address bits 9..0 are all 1 when RAS falls. Any other row value leaves the mode unchanged.
- R3: A CAS-before-RAS refresh with WE high clears test mode.
- R4: A RAS cycle in which CAS stays high until RAS rises again (RAS-only refresh) clears test mode.
- R5: A hidden refresh clears test mode. This is a read whose CAS stays low while RAS rises and falls again. The read data stays driven during the hidden refresh.
- R6: In test mode, a further write-CAS-before-RAS cycle and ordinary read cycles leave test mode set.
- R7: The cell location is {row[1:0], col[2]}, giving 8 locations. In normal mode col[1:0] selects sub-block 0..3. A write changes only that sub-block for each pin, and a read returns that sub-block's bit on each pin.
- R8: A test-mode write stores each pin's value into all four sub-blocks of that pin at the addressed location.
- R9: A test-mode read drives each pin with 1 when its four sub-block bits at the location are equal, and with 0 when they differ.
- R10: After reset, test mode is clear and the outputs are disabled. Output enable is high only after a read's CAS fall, until CAS is seen high. Data reads 0 while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 10 | Multiplexed row/column address |
| din | input | 4 | Write data, one bit per pin |
| dout | output | 4 | Read data or per-pin compare result |
| dout_oe | output | 1 | Output enable for dout |
| test_active | output | 1 | Test-mode flag |

## Verification
Every location and sub-block is first written in normal mode with an arithmetic pattern that differs per sub-block, then read back. This separates a correct sub-block select from crossed or merged sub-blocks. Test-mode reads of that mixed data, then of uniform test-mode writes, then after a single normal-mode write that corrupts one sub-block, show the compare reporting both agreement and disagreement per pin. Near-miss entry keys, a repeated entry cycle, and each of the three exit refresh kinds check the flag's transitions one at a time.

// File: rtl/dtm_pkg.sv
// Package: shared types for the DRAM test-mode controller.
// Assumes a single clock domain; strobes are already synchronous.
package dtm_pkg;

    // Kind of refresh recognised on a RAS edge
    typedef enum logic [2:0] {
        EV_NONE    = 3'd0,
        EV_WCBR    = 3'd1,
        EV_CBR     = 3'd2,
        EV_HIDDEN  = 3'd3,
        EV_RASONLY = 3'd4
    } refresh_e;

endpackage

// File: rtl/dtm_strobe_decode.sv
// Module: strobe decoder. Detects RAS/CAS edges on the system clock,
// classifies each RAS cycle and reports access starts and refresh events.
// Assumes strobes are synchronous to clk and held at least one clock.
module dtm_strobe_decode
    import dtm_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output refresh_e          evt,
    output logic              acc_go,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] row_q,
    output logic              rd_open
);

    logic ras_q, cas_q;
    logic pend;
    logic hid_arm;
    logic ras_fall, ras_rise, cas_fall;

    // Edge detection against the previous sample
    always_comb begin
        ras_fall = ras_q & ~ras_n;
        ras_rise = ~ras_q & ras_n;
        cas_fall = cas_q & ~cas_n;
    end

    // Refresh classification and access start
    always_comb begin
        evt = EV_NONE;
        if (ras_fall && !cas_n) begin
            if (hid_arm)    evt = EV_HIDDEN;
            else if (!we_n) evt = EV_WCBR;
            else            evt = EV_CBR;
        end else if (ras_rise && pend) begin
            evt = EV_RASONLY;
        end
        acc_go = cas_fall && !ras_n && pend;
        acc_wr = !we_n;
    end

    // Strobe history and row address latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
            row_q <= '0;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            if (ras_fall) row_q <= addr;
        end
    end

    // Pending flag: RAS is low and CAS has not yet fallen
    always_ff @(posedge clk) begin
        if (!rst_n)                   pend <= 1'b0;
        else if (ras_fall && cas_n)   pend <= 1'b1;
        else if (acc_go || ras_rise)  pend <= 1'b0;
    end

    // Open read: held from a read CAS fall until CAS is seen high
    always_ff @(posedge clk) begin
        if (!rst_n)               rd_open <= 1'b0;
        else if (cas_n)           rd_open <= 1'b0;
        else if (acc_go && we_n)  rd_open <= 1'b1;
    end

    // Hidden refresh arm: RAS rose during an open read with CAS low
    always_ff @(posedge clk) begin
        if (!rst_n)                     hid_arm <= 1'b0;
        else if (cas_n)                 hid_arm <= 1'b0;
        else if (ras_fall)              hid_arm <= 1'b0;
        else if (ras_rise && rd_open)   hid_arm <= 1'b1;
    end

    // R1: an open read only starts from a read access
    assert_read_from_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_open) |-> $past(acc_go && we_n));

    // R5: hidden refresh arm implies CAS was held low
    assert_hidden_cas_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hid_arm |-> $past(!cas_n));

    // R1: a refresh event and an access start never coincide
    assert_evt_access_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != EV_NONE) |-> !acc_go);

endmodule

// File: rtl/dtm_mode_track.sv
// Module: test-mode flag. Sets on a keyed write-CAS-before-RAS cycle and
// clears on CBR, RAS-only or hidden refresh. Assumes one event per clock.
module dtm_mode_track
    import dtm_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int KEY_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  refresh_e          evt,
    input  logic [ADDR_W-1:0] addr,
    output logic              test_mode
);

    logic key_ok;
    logic exit_evt;

    // Entry key and exit decode
    always_comb begin
        key_ok   = &addr[KEY_W-1:0];
        exit_evt = (evt == EV_CBR) || (evt == EV_HIDDEN) || (evt == EV_RASONLY);
    end

    // Test-mode flag register
    always_ff @(posedge clk) begin
        if (!rst_n)                          test_mode <= 1'b0;
        else if (exit_evt)                   test_mode <= 1'b0;
        else if (evt == EV_WCBR && key_ok)   test_mode <= 1'b1;
    end

    // R2: entry only through a keyed WCBR cycle
    assert_entry_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> $past(evt == EV_WCBR && (&addr[KEY_W-1:0])));

    // R3: exit only through one of the exit refresh kinds
    assert_exit_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_mode) |-> $past(evt == EV_CBR || evt == EV_HIDDEN || evt == EV_RASONLY));

    // R6: WCBR in test mode keeps the flag
    assert_wcbr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && evt == EV_WCBR) |=> test_mode);

endmodule

// File: rtl/dtm_cell_array.sv
// Module: cell array with write steering and read compression.
// Each pin owns SUBS sub-blocks of LOCS bits. Normal accesses pick one
// sub-block by col[1:0]; test accesses fan out on write and compare on read.
module dtm_cell_array #(
    parameter int ADDR_W   = 10,
    parameter int PINS     = 4,
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_go,
    input  logic              acc_wr,
    input  logic              test_mode,
    input  logic [ADDR_W-1:0] row_q,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PINS-1:0]   din,
    input  logic              rd_open,
    input  logic              cas_n,
    output logic [PINS-1:0]   dout,
    output logic              dout_oe
);

    localparam int SEL_W = 2;
    localparam int SUBS  = 1 << SEL_W;
    localparam int LOC_W = ROW_BITS + COL_BITS;
    localparam int LOCS  = 1 << LOC_W;

    logic [LOCS-1:0] mem [PINS][SUBS];
    logic [LOC_W-1:0] loc_now, loc_q;
    logic [SEL_W-1:0] sel_now, sel_q;
    logic             cmp_q;

    // Location and sub-block select from the latched row and live column
    always_comb begin
        loc_now = {row_q[ROW_BITS-1:0], addr[SEL_W +: COL_BITS]};
        sel_now = addr[SEL_W-1:0];
    end

    // Access latch: location, select and read flavour
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_q <= '0;
            sel_q <= '0;
            cmp_q <= 1'b0;
        end else if (acc_go) begin
            loc_q <= loc_now;
            sel_q <= sel_now;
            cmp_q <= test_mode;
        end
    end

    // Cell writes: one sub-block in normal mode, all in test mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < PINS; p++)
                for (int s = 0; s < SUBS; s++)
                    mem[p][s] <= '0;
        end else if (acc_go && acc_wr) begin
            for (int p = 0; p < PINS; p++)
                for (int s = 0; s < SUBS; s++)
                    if (test_mode || sel_now == SEL_W'(s))
                        mem[p][s][loc_now] <= din[p];
        end
    end

    assign dout_oe = rd_open;

    // Per-pin read path: direct bit or four-way compare
    generate
        for (genvar gp = 0; gp < PINS; gp++) begin : g_pin
            logic [SUBS-1:0] bits;
            logic            same;

            // Gather the pin's sub-block bits at the latched location
            always_comb begin
                for (int s = 0; s < SUBS; s++) bits[s] = mem[gp][s][loc_q];
                same = (bits == '0) || (&bits);
                if (!rd_open)   dout[gp] = 1'b0;
                else if (cmp_q) dout[gp] = same;
                else            dout[gp] = bits[sel_q];
            end

            // R8: a test write leaves all sub-blocks equal to the pin value
            assert_test_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
                $past(acc_go && acc_wr && test_mode) |->
                    (bits == {SUBS{$past(din[gp])}}));
        end
    endgenerate

    // R10: output enable only while CAS was low
    assert_oe_cas_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> $past(!cas_n));

endmodule

// File: rtl/dram_testmode_ctrl.sv
// Module: top of the DRAM compressed test-mode controller.
// Ties the strobe decoder, mode flag and cell array together.
// Assumes strobes synchronous to clk; reset is synchronous, active low.
module dram_testmode_ctrl #(
    parameter int ADDR_W   = 10,
    parameter int PINS     = 4,
    parameter int KEY_W    = 10,
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PINS-1:0]   din,
    output logic [PINS-1:0]   dout,
    output logic              dout_oe,
    output logic              test_active
);

    dtm_pkg::refresh_e evt;
    logic              acc_go, acc_wr, rd_open;
    logic [ADDR_W-1:0] row_q;

    dtm_strobe_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .evt(evt), .acc_go(acc_go), .acc_wr(acc_wr),
        .row_q(row_q), .rd_open(rd_open)
    );

    dtm_mode_track #(.ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .evt(evt), .addr(addr), .test_mode(test_active)
    );

    dtm_cell_array #(
        .ADDR_W(ADDR_W), .PINS(PINS), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)
    ) u_cells (
        .clk(clk), .rst_n(rst_n), .acc_go(acc_go), .acc_wr(acc_wr),
        .test_mode(test_active), .row_q(row_q), .addr(addr), .din(din),
        .rd_open(rd_open), .cas_n(cas_n), .dout(dout), .dout_oe(dout_oe)
    );

endmodule

// File: tb/test_dram_testmode_ctrl.sv
// Bench: sweeps all locations and sub-blocks, toggles test mode through
// every entry/exit path and compares against an arithmetic model.
module test_dram_testmode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [9:0] addr = '0;
    logic [3:0] din = '0;
    logic [3:0] dout;
    logic       dout_oe, test_active;

    int checks = 0;
    int errors = 0;
    logic       rm [4][4][8];
    logic       ref_test = 1'b0;

    always #10 clk = ~clk;

    dram_testmode_ctrl i_dram_testmode_ctrl (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .test_active(test_active)
    );

    task automatic tick; @(negedge clk); endtask

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    function automatic logic [3:0] pat(input int loc, input int sub);
        return 4'((loc * 5 + sub * 3 + 1) & 15);
    endfunction

    function automatic logic [3:0] exp_read(input logic [9:0] row, input logic [9:0] col);
        logic [3:0] r;
        int loc, sel;
        loc = {row[1:0], col[2]};
        sel = col[1:0];
        for (int p = 0; p < 4; p++) begin
            if (ref_test)
                r[p] = (rm[p][0][loc] == rm[p][1][loc]) && (rm[p][1][loc] == rm[p][2][loc])
                       && (rm[p][2][loc] == rm[p][3][loc]);
            else
                r[p] = rm[p][sel][loc];
        end
        return r;
    endfunction

    task automatic write_cyc(input logic [9:0] row, input logic [9:0] col, input logic [3:0] d);
        int loc;
        ras_n = 0; addr = row; tick;
        addr = col; we_n = 0; din = d; cas_n = 0; tick;
        ras_n = 1; cas_n = 1; we_n = 1; tick; tick;
        loc = {row[1:0], col[2]};
        for (int p = 0; p < 4; p++)
            for (int s = 0; s < 4; s++)
                if (ref_test || s == int'(col[1:0])) rm[p][s][loc] = d[p];
    endtask

    task automatic read_cyc(input logic [9:0] row, input logic [9:0] col,
                            output logic [3:0] d, output logic oe, output logic oe_after);
        ras_n = 0; addr = row; tick;
        addr = col; cas_n = 0; tick;
        d = dout; oe = dout_oe;
        ras_n = 1; cas_n = 1; tick;
        oe_after = dout_oe; tick;
    endtask

    task automatic cas_first(input logic [9:0] row, input logic wr);
        cas_n = 0; we_n = ~wr; tick;
        ras_n = 0; addr = row; tick;
        ras_n = 1; cas_n = 1; we_n = 1; tick; tick;
    endtask

    task automatic ras_only(input logic [9:0] row);
        ras_n = 0; addr = row; tick; tick;
        ras_n = 1; tick; tick;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run;
    end

    initial begin
        logic [3:0] d;
        logic oe, oe_a;
        logic [9:0] row, col;
        for (int p = 0; p < 4; p++)
            for (int s = 0; s < 4; s++)
                for (int l = 0; l < 8; l++) rm[p][s][l] = 1'b0;

        tick; tick; tick;
        rst_n = 1; tick;
        chk("R10 reset test flag", {3'b0, test_active}, 4'h0);
        chk("R10 reset oe", {3'b0, dout_oe}, 4'h0);

        // R7 R1: normal-mode fill of every location and sub-block
        for (int l = 0; l < 8; l++)
            for (int s = 0; s < 4; s++) begin
                row = 10'(l >> 1); col = 10'(((l & 1) << 2) | s);
                write_cyc(row, col, pat(l, s));
            end
        for (int l = 0; l < 8; l++)
            for (int s = 0; s < 4; s++) begin
                row = 10'(l >> 1); col = 10'(((l & 1) << 2) | s);
                read_cyc(row, col, d, oe, oe_a);
                chk("R7 normal read", d, pat(l, s));
                chk("R10 oe during read", {3'b0, oe}, 4'h1);
                chk("R10 oe after CAS high", {3'b0, oe_a}, 4'h0);
            end

        // R2: near-miss keys do not enter
        cas_first(10'h3FE, 1'b1);
        chk("R2 key 3FE ignored", {3'b0, test_active}, 4'h0);
        cas_first(10'h1FF, 1'b1);
        chk("R2 key 1FF ignored", {3'b0, test_active}, 4'h0);
        cas_first(10'h3FF, 1'b0);
        chk("R2 CBR with key no entry", {3'b0, test_active}, 4'h0);
        cas_first(10'h3FF, 1'b1);
        ref_test = 1;
        chk("R2 keyed entry", {3'b0, test_active}, 4'h1);

        // R9: compare over mixed normal-mode data
        for (int l = 0; l < 8; l++) begin
            row = 10'(l >> 1); col = 10'((l & 1) << 2);
            read_cyc(row, col, d, oe, oe_a);
            chk("R9 compare mixed", d, exp_read(row, col));
        end

        // R8 R9: uniform test writes then all-ones compare
        for (int l = 0; l < 8; l++) begin
            row = 10'(l >> 1); col = 10'((l & 1) << 2 | (l & 3));
            write_cyc(row, col, 4'((l * 3 + 5) & 15));
        end
        for (int l = 0; l < 8; l++) begin
            row = 10'(l >> 1); col = 10'((l & 1) << 2);
            read_cyc(row, col, d, oe, oe_a);
            chk("R9 compare uniform", d, 4'hF);
        end

        // R6: repeated entry cycle and reads keep test mode
        cas_first(10'h000, 1'b1);
        chk("R6 WCBR keeps test", {3'b0, test_active}, 4'h1);
        chk("R6 reads keep test", {3'b0, test_active}, 4'h1);

        // R4: RAS-only exit, then check fan-out reached every sub-block
        ras_only(10'h155);
        ref_test = 0;
        chk("R4 RAS-only exit", {3'b0, test_active}, 4'h0);
        for (int l = 0; l < 8; l++)
            for (int s = 0; s < 4; s++) begin
                row = 10'(l >> 1); col = 10'(((l & 1) << 2) | s);
                read_cyc(row, col, d, oe, oe_a);
                chk("R8 fan-out per sub-block", d, 4'((l * 3 + 5) & 15));
            end

        // R9: corrupt pin 1 of sub-block 2 at location 5, recompare
        write_cyc(10'h002, 10'h006, 4'(((5 * 3 + 5) & 15) ^ 2));
        cas_first(10'h3FF, 1'b1);
        ref_test = 1;
        read_cyc(10'h002, 10'h004, d, oe, oe_a);
        chk("R9 corrupted pin", d, 4'hD);
        chk("R9 corrupted model", d, exp_read(10'h002, 10'h004));

        // R3: CBR exit
        cas_first(10'h0AA, 1'b0);
        ref_test = 0;
        chk("R3 CBR exit", {3'b0, test_active}, 4'h0);
        cas_first(10'h0AA, 1'b0);
        chk("R3 CBR in normal stays", {3'b0, test_active}, 4'h0);

        // R5: hidden refresh exit with data held
        cas_first(10'h3FF, 1'b1);
        ref_test = 1;
        chk("R5 re-entry", {3'b0, test_active}, 4'h1);
        ras_n = 0; addr = 10'h001; tick;
        addr = 10'h000; cas_n = 0; tick;
        chk("R5 hidden read data", dout, exp_read(10'h001, 10'h000));
        ras_n = 1; tick;
        ras_n = 0; tick;
        chk("R5 hidden exit", {3'b0, test_active}, 4'h0);
        chk("R5 data held", {3'b0, dout_oe}, 4'h1);
        chk("R5 held value", dout, 4'hF);
        ras_n = 1; cas_n = 1; tick; tick;
        ref_test = 0;
        chk("R10 oe released", {3'b0, dout_oe}, 4'h0);

        finish_run;
    end

endmodule